// File: doc/BRIEF.md
# Start-up Delay and Brownout Reset Supervisor

This block produces the reset that holds a processor core and the enable that paces its instruction clock. Four things can put the core into reset: the power-on reset, the external master-clear pin, a timeout pulse from the watchdog, and the flag raised by a brownout comparator. Once every source has gone quiet, the block keeps the core in reset for a start-up delay. That delay is counted in pulses of a slow tick, which comes from the watchdog oscillator (nominally 14 kHz) and arrives already converted to a one-cycle strobe in the oscillator clock domain.

On the configurable variant a two-bit field picks one of four delay lengths. The default tick counts, 1, 256, 840 and 13440, give about 0.07 ms, 18 ms, 60 ms and 960 ms at 14 kHz. The reduced variant always uses one fixed length and ignores the field. A source that comes back while the delay is running sends the count back to zero. The brownout flag holds the core in reset for as long as it stays active, but only while brownout detection is enabled. When the flag clears, the full delay runs before the core starts again from its reset address.

The instruction enable is high on every oscillator cycle in turbo mode and on one cycle in four otherwise. The divide-by-four phase is held at zero during reset, so the first cycle after release always carries an enable.

Top module: `rst_supervisor`

## Requirements
- R1: While `arst_ni` is low, `core_rst_o` is 1 and `inst_en_o` is 0, whatever slow ticks arrive.
- R2: Driving `mclr_ni` low sets `core_rst_o` to 1 at once, without waiting for a clock edge. Releasing `arst_ni` or `mclr_ni` takes effect after SYNC_STAGES clock edges (2 by default).
- R3: Once no source is active, `core_rst_o` falls on the clock edge that samples the N-th `slow_tick_i` pulse. N is set by `dly_sel_i`: 0 selects TICKS_SHORT, 1 TICKS_MID, 2 TICKS_LONG, 3 TICKS_MAX.
- R4: With CONFIGURABLE=0, N is TICKS_FIXED for every value of `dly_sel_i`.
- R5: While `bo_en_i` and `bo_flag_i` are both 1, `core_rst_o` is 1 from the third clock edge on and stays at 1. After the flag clears, the full delay of R3 runs again.
- R6: While `bo_en_i` is 0, `bo_flag_i` has no effect on `core_rst_o`.
- R7: A one-cycle `wdt_timeout_i` pulse makes `core_rst_o` 1 after the edge that samples it, and the delay count restarts.
- R8: Any source that becomes active during the delay count restarts the count from zero, so N further ticks are needed.
- R9: With `turbo_i`=1 and the core out of reset, `inst_en_o` is 1 on every cycle.
- R10: With `turbo_i`=0, `inst_en_o` is 1 on the first cycle after `core_rst_o` falls and then on every fourth cycle, 0 on all others.
- R11: `inst_en_o` is 0 whenever `core_rst_o` is 1.
- R12: Clock cycles without a `slow_tick_i` pulse do not advance the delay count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| arst_ni | input | 1 | Power-on reset, asynchronous, active low |
| mclr_ni | input | 1 | External master clear, asynchronous, active low |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe, synchronous, one cycle |
| bo_flag_i | input | 1 | Brownout comparator flag, asynchronous level |
| bo_en_i | input | 1 | Brownout detection enable |
| dly_sel_i | input | 2 | Start-up delay select (configurable variant only) |
| turbo_i | input | 1 | 1: enable every cycle; 0: enable every fourth cycle |
| slow_tick_i | input | 1 | One-cycle strobe from the slow watchdog oscillator |
| core_rst_o | output | 1 | Core reset, active high |
| inst_en_o | output | 1 | Instruction clock enable |

## Verification
Each result comes due a fixed number of edges after its stimulus:
- A master clear shows up on `core_rst_o` with no edge at all.
- A watchdog strobe shows up after one edge.
- A brownout flag shows up after three edges, because of its two-stage synchronizer.
- A pin release reaches the counter after two edges.
- The end of the delay appears right after the edge that samples the last tick. The first instruction enable appears in that same cycle.

The bench drives inputs on falling edges and samples on falling edges. Before the first tick it waits out the synchronizer latency with a margin. After every tick it checks the reset level against the tick count expected for the selected setting, for both the configurable and the fixed variant.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
   // Start-up delay selection codes; the numeric value is the select field.
   typedef enum logic [1:0] {
      DLY_SHORT = 2'd0,
      DLY_MID   = 2'd1,
      DLY_LONG  = 2'd2,
      DLY_MAX   = 2'd3
   } dly_sel_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/rsup_async_rst_sync.sv
// Asynchronous assertion, synchronous release of a combined active-low reset.
module rsup_async_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic rst_active_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_active_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/rsup_level_sync.sv
// Multi-flop synchronizer for a level input.
module rsup_level_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) chain_q <= '0;
      else          chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rsup_dly_limit.sv
// Tick count for the start-up delay: selectable or fixed variant (R3, R4).
module rsup_dly_limit
   import rsup_pkg::*;
#(
   parameter bit          CONFIGURABLE = 1'b1,
   parameter int unsigned CNT_W        = 14,
   parameter int unsigned TICKS_SHORT  = 1,
   parameter int unsigned TICKS_MID    = 256,
   parameter int unsigned TICKS_LONG   = 840,
   parameter int unsigned TICKS_MAX    = 13440,
   parameter int unsigned TICKS_FIXED  = 256
) (
   input  logic [1:0]       sel_i,
   output logic [CNT_W-1:0] limit_o
);
   generate
      if (CONFIGURABLE) begin : g_select
         dly_sel_e sel;
         assign sel = dly_sel_e'(sel_i);
         always_comb begin
            unique case (sel)
               DLY_SHORT: limit_o = CNT_W'(TICKS_SHORT);
               DLY_MID:   limit_o = CNT_W'(TICKS_MID);
               DLY_LONG:  limit_o = CNT_W'(TICKS_LONG);
               default:   limit_o = CNT_W'(TICKS_MAX);
            endcase
         end
      end else begin : g_fixed
         logic [1:0] unused_sel;
         assign unused_sel = sel_i;
         assign limit_o    = CNT_W'(TICKS_FIXED);
      end
   endgenerate
endmodule

// File: rtl/rsup_startup_timer.sv
// Counts slow ticks once all sources are quiet; any hold restarts from zero (R8, R12).
module rsup_startup_timer #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk_i,
   input  logic             arst_ni,
   input  logic             hold_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic [CNT_W-1:0] last_cnt;

   assign last_cnt = limit_i - CNT_W'(1);

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (hold_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q && tick_i) begin
         if (cnt_q >= last_cnt) done_q <= 1'b1;
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign done_o = done_q;
endmodule

// File: rtl/rsup_iclk_div.sv
// Instruction enable: every cycle (turbo) or one in DIV, phase cleared in reset (R9, R10, R11).
module rsup_iclk_div #(
   parameter int unsigned DIV = 4
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic core_rst_i,
   input  logic turbo_i,
   output logic en_o
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [PW-1:0] phase_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni)        phase_q <= '0;
      else if (core_rst_i) phase_q <= '0;
      else if (phase_q == PW'(DIV - 1)) phase_q <= '0;
      else                 phase_q <= phase_q + PW'(1);
   end

   assign en_o = ~core_rst_i & (turbo_i | (phase_q == '0));
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
   import rsup_pkg::*;
#(
   parameter bit          CONFIGURABLE = 1'b1,
   parameter int unsigned TICKS_SHORT  = 1,
   parameter int unsigned TICKS_MID    = 256,
   parameter int unsigned TICKS_LONG   = 840,
   parameter int unsigned TICKS_MAX    = 13440,
   parameter int unsigned TICKS_FIXED  = 256,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned SLOW_DIV     = 4
) (
   input  logic       clk_i,
   input  logic       arst_ni,
   input  logic       mclr_ni,
   input  logic       wdt_timeout_i,
   input  logic       bo_flag_i,
   input  logic       bo_en_i,
   input  logic [1:0] dly_sel_i,
   input  logic       turbo_i,
   input  logic       slow_tick_i,
   output logic       core_rst_o,
   output logic       inst_en_o
);
   localparam int unsigned MAX_SEL   = max4(TICKS_SHORT, TICKS_MID, TICKS_LONG, TICKS_MAX);
   localparam int unsigned MAX_TICKS = (TICKS_FIXED > MAX_SEL) ? TICKS_FIXED : MAX_SEL;
   localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

   initial begin
      if (TICKS_SHORT == 0 || TICKS_MID == 0 || TICKS_LONG == 0 ||
          TICKS_MAX == 0 || TICKS_FIXED == 0)
         $error("rst_supervisor: every delay needs at least one tick");
      if (SYNC_STAGES < 2)
         $error("rst_supervisor: SYNC_STAGES must be at least 2");
      if (SLOW_DIV < 2 || (SLOW_DIV & (SLOW_DIV - 1)) != 0)
         $error("rst_supervisor: SLOW_DIV must be a power of two of at least 2");
   end

   logic pin_rst_n;
   logic pin_rst_active;
   logic bo_sync;
   logic hold;
   logic [CNT_W-1:0] limit;
   logic timer_done;

   // R1, R2: power-on and master clear join into one asynchronously asserted reset
   assign pin_rst_n = arst_ni & mclr_ni;

   rsup_async_rst_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk_i        (clk_i),
      .rst_ni       (pin_rst_n),
      .rst_active_o (pin_rst_active)
   );

   rsup_level_sync #(.STAGES(SYNC_STAGES)) u_bo_sync (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .d_i     (bo_flag_i),
      .q_o     (bo_sync)
   );

   // R5, R6, R7: every active source holds the timer at zero
   assign hold = pin_rst_active | wdt_timeout_i | (bo_en_i & bo_sync);

   rsup_dly_limit #(
      .CONFIGURABLE (CONFIGURABLE),
      .CNT_W        (CNT_W),
      .TICKS_SHORT  (TICKS_SHORT),
      .TICKS_MID    (TICKS_MID),
      .TICKS_LONG   (TICKS_LONG),
      .TICKS_MAX    (TICKS_MAX),
      .TICKS_FIXED  (TICKS_FIXED)
   ) u_limit (
      .sel_i   (dly_sel_i),
      .limit_o (limit)
   );

   rsup_startup_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i   (clk_i),
      .arst_ni (arst_ni),
      .hold_i  (hold),
      .tick_i  (slow_tick_i),
      .limit_i (limit),
      .done_o  (timer_done)
   );

   assign core_rst_o = ~timer_done | pin_rst_active;

   rsup_iclk_div #(.DIV(SLOW_DIV)) u_div (
      .clk_i      (clk_i),
      .arst_ni    (arst_ni),
      .core_rst_i (core_rst_o),
      .turbo_i    (turbo_i),
      .en_o       (inst_en_o)
   );
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker (
   input logic clk_i,
   input logic arst_ni,
   input logic wdt_timeout_i,
   input logic bo_flag_i,
   input logic bo_en_i,
   input logic turbo_i,
   input logic slow_tick_i,
   input logic core_rst_o,
   input logic inst_en_o
);
   p_por_holds_r1: assert property (@(posedge clk_i) !arst_ni |-> core_rst_o);

   p_release_on_tick_r3: assert property (@(posedge clk_i) disable iff (!arst_ni)
      $fell(core_rst_o) |-> $past(slow_tick_i));

   p_bo_holds_r5: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (bo_en_i && bo_flag_i && $past(bo_en_i && bo_flag_i) && $past(bo_en_i && bo_flag_i, 2))
      |=> core_rst_o);

   p_wdt_resets_r7: assert property (@(posedge clk_i) disable iff (!arst_ni)
      wdt_timeout_i |=> core_rst_o);

   p_turbo_every_r9: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (!core_rst_o && turbo_i) |-> inst_en_o);

   p_div_gap_r10: assert property (@(posedge clk_i) disable iff (!arst_ni)
      (inst_en_o && !turbo_i) |=> (!inst_en_o || turbo_i));

   p_no_en_in_rst_r11: assert property (@(posedge clk_i) core_rst_o |-> !inst_en_o);
endmodule

bind rst_supervisor rsup_checker u_chk (
   .clk_i         (clk_i),
   .arst_ni       (arst_ni),
   .wdt_timeout_i (wdt_timeout_i),
   .bo_flag_i     (bo_flag_i),
   .bo_en_i       (bo_en_i),
   .turbo_i       (turbo_i),
   .slow_tick_i   (slow_tick_i),
   .core_rst_o    (core_rst_o),
   .inst_en_o     (inst_en_o)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
   logic clk = 1'b0;
   logic arst_n, mclr_n, wdt, bo_flag, bo_en, turbo, tick;
   logic [1:0] sel;
   logic rst_c, en_c, rst_f, en_f;
   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   localparam int T0 = 1, T1 = 3, T2 = 4, T3 = 6, TF = 3;

   always #2 clk = ~clk;

   rst_supervisor #(.CONFIGURABLE(1'b1), .TICKS_SHORT(T0), .TICKS_MID(T1),
                    .TICKS_LONG(T2), .TICKS_MAX(T3), .TICKS_FIXED(TF)) u_dut (
      .clk_i(clk), .arst_ni(arst_n), .mclr_ni(mclr_n), .wdt_timeout_i(wdt),
      .bo_flag_i(bo_flag), .bo_en_i(bo_en), .dly_sel_i(sel), .turbo_i(turbo),
      .slow_tick_i(tick), .core_rst_o(rst_c), .inst_en_o(en_c));

   rst_supervisor #(.CONFIGURABLE(1'b0), .TICKS_SHORT(T0), .TICKS_MID(T1),
                    .TICKS_LONG(T2), .TICKS_MAX(T3), .TICKS_FIXED(TF)) u_dut_fix (
      .clk_i(clk), .arst_ni(arst_n), .mclr_ni(mclr_n), .wdt_timeout_i(wdt),
      .bo_flag_i(bo_flag), .bo_en_i(bo_en), .dly_sel_i(sel), .turbo_i(turbo),
      .slow_tick_i(tick), .core_rst_o(rst_f), .inst_en_o(en_f));

   function automatic int sel_ticks(input logic [1:0] s);
      case (s)
         2'd0: return T0;
         2'd1: return T1;
         2'd2: return T2;
         default: return T3;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
   endtask

   // After the sources are released: wait out the synchronizer, then tick.
   // Checks the reset level before each tick; lf < 0 skips the fixed instance.
   task automatic measure(input int lc, input int lf, input string tag);
      int nt;
      nt = ((lc > lf) ? lc : lf) + 1;
      cyc(8); // R12: cycles without a tick leave the count unchanged
      for (int i = 0; i <= nt; i++) begin
         check(rst_c == (i < lc), {tag, " cfg reset level"}, rst_c, (i < lc));
         if (i < lc) check(en_c == 1'b0, "R11 enable low in reset", en_c, 0);
         if (lf >= 0) check(rst_f == (i < lf), {tag, " fixed reset level"}, rst_f, (i < lf));
         if (i < nt) pulse_tick();
      end
   endtask

   initial begin
      arst_n = 1'b0; mclr_n = 1'b1; wdt = 1'b0; bo_flag = 1'b0; bo_en = 1'b0;
      turbo = 1'b0; tick = 1'b0; sel = 2'd0;
      cyc(3);
      // R1: reset state, ticks ignored
      check(rst_c == 1'b1, "R1 core reset", rst_c, 1);
      check(en_c == 1'b0, "R1 enable", en_c, 0);
      pulse_tick(); pulse_tick();
      check(rst_c == 1'b1 && rst_f == 1'b1, "R1 ticks during reset", rst_c, 1);

      // R3 / R4: sweep every delay select on both variants
      for (int s = 0; s < 4; s++) begin
         sel = 2'(s);
         arst_n = 1'b0;
         cyc(2);
         arst_n = 1'b1;
         measure(sel_ticks(2'(s)), TF, (s[0] ? "R3/R4 odd sel" : "R3/R4 even sel"));
      end
      sel = 2'd3;

      // R2: master clear asserts without a clock edge
      #1 mclr_n = 1'b0;
      #0.5;
      check(rst_c == 1'b1 && rst_f == 1'b1, "R2 immediate assert", rst_c, 1);
      @(negedge clk);
      mclr_n = 1'b1;
      measure(T3, TF, "R2 release");

      // R8: master clear during the count restarts it
      mclr_n = 1'b0; cyc(1); mclr_n = 1'b1;
      cyc(8);
      pulse_tick(); pulse_tick(); pulse_tick();
      check(rst_c == 1'b1, "R8 mid count", rst_c, 1);
      mclr_n = 1'b0; cyc(1); mclr_n = 1'b1;
      measure(T3, TF, "R8 restart");

      // R7: watchdog pulse asserts reset and restarts count
      wdt = 1'b1; cyc(1); wdt = 1'b0;
      check(rst_c == 1'b1 && rst_f == 1'b1, "R7 watchdog assert", rst_c, 1);
      cyc(3);
      pulse_tick(); pulse_tick(); pulse_tick(); pulse_tick();
      wdt = 1'b1; cyc(1); wdt = 1'b0;
      measure(T3, TF, "R7 restart");

      // R6: brownout flag ignored while detection is disabled
      bo_en = 1'b0;
      for (int k = 0; k < 12; k++) begin
         bo_flag = k[1];
         if (k[0]) pulse_tick(); else cyc(1);
         check(rst_c == 1'b0 && rst_f == 1'b0, "R6 flag ignored", rst_c, 0);
      end
      bo_flag = 1'b0;
      cyc(3);

      // R5: brownout held for its whole duration, then full delay
      bo_en = 1'b1; bo_flag = 1'b1;
      cyc(3);
      for (int k = 0; k < 20; k++) begin
         check(rst_c == 1'b1 && rst_f == 1'b1, "R5 held in brownout", rst_c, 1);
         pulse_tick();
      end
      bo_flag = 1'b0;
      measure(T3, TF, "R5 resume");
      bo_en = 1'b0;

      // R9: turbo enables every cycle
      turbo = 1'b1;
      for (int k = 0; k < 8; k++) begin
         cyc(1);
         check(en_c == 1'b1 && en_f == 1'b1, "R9 turbo enable", en_c, 1);
      end

      // R10: divide by four, first enable right after release
      turbo = 1'b0;
      sel = 2'd1;
      wdt = 1'b1; cyc(1); wdt = 1'b0;
      cyc(8);
      pulse_tick(); pulse_tick(); pulse_tick();
      for (int k = 0; k < 13; k++) begin
         check(rst_c == 1'b0, "R10 out of reset", rst_c, 0);
         check(en_c == ((k % 4) == 0), "R10 enable phase", en_c, ((k % 4) == 0));
         cyc(1);
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule